// File: doc/BRIEF.md
# Indirect Configuration Register Bank

This block sits between an 8-bit parallel host port and the timing logic of a serial bus controller. The host sees only two locations: a pointer register and a data window. The pointer picks one of eight internal slots, and the data window reads or writes the selected slot. The slots are:

- own address
- timeout
- operating mode
- SCL low-phase count
- SCL high-phase count
- a reset slot

The mode and both phase counts drive a clock generator outside this block.

The reset slot is guarded by a two-byte unlock. With the pointer on the reset slot, the host writes KEY1 (0xA5) and then KEY2 (0x5A) through the data window. This raises a one-cycle soft-reset pulse. That pulse returns every slot and the pointer to their defaults. Software can probe for the bank by writing the own-address slot, writing 0x00 to the timeout slot, and reading the own-address slot back.

The unlock machine has three states: `UL_IDLE`, `UL_ARMED` and `UL_FIRE`. Its transitions are:

| Transition | Condition |
|---|---|
| IDLE→ARMED | Data write of KEY1 while the pointer is on the reset slot |
| ARMED→FIRE | Data write of KEY2 while the pointer is on the reset slot |
| ARMED→IDLE | Any other host write, to either location |
| FIRE→IDLE | Always, after one cycle |

All other cases hold the current state.

Top module: `ibank_host`

## Requirements
- R1: After `rst_n` is released, the pointer reads 0 and the slots hold their defaults: own address 0x60, timeout 0xFF, mode 0, low count 0x9D, high count 0x86.
- R2: A write with `host_sel`=0 loads `host_wdata[2:0]` into the pointer. A read with `host_sel`=0 returns the pointer zero-extended to 8 bits.
- R3: A write with `host_sel`=1 loads the slot selected by the pointer. A read with `host_sel`=1 returns that slot. Slot indices are: 0 own address, 1 timeout, 2 mode, 3 low count, 4 high count, 5 reset.
- R4: Writing 0x00 to the timeout slot leaves the own-address slot unchanged.
- R5: The mode slot keeps `host_wdata[1:0]` and drives `mode_o`. The encoding is 0 standard, 1 fast, 2 fast-plus, 3 turbo. Its upper bits read as 0.
- R6: The low and high count slots are written separately and drive `scl_lo_o` and `scl_hi_o` from the cycle after the write.
- R7: With the pointer at 5, a data write of 0xA5 followed by a data write of 0x5A raises `soft_rst_o` for exactly the one cycle after the 0x5A write.
- R8: At the end of the `soft_rst_o` cycle, every slot and the pointer return to their R1 defaults.
- R9: After 0xA5, any write other than a data write of 0x5A to slot 5 returns the unlock machine to idle. This covers a different byte, a repeated 0xA5, and a pointer write. A later 0x5A then gives no pulse.
- R10: Slots 5, 6 and 7 read 0x00. Data writes to them change no slot or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one write per cycle when high |
| host_sel | input | 1 | 0 selects the pointer, 1 selects the data window |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the location chosen by `host_sel` (combinational) |
| mode_o | output | 2 | Operating mode to the clock generator |
| scl_lo_o | output | 8 | SCL low-phase count |
| scl_hi_o | output | 8 | SCL high-phase count |
| soft_rst_o | output | 1 | One-cycle controller soft-reset pulse |

## Verification
The bench builds the block with its default parameters. These are an 8-bit data path, a 3-bit pointer, keys 0xA5/0x5A, and defaults that differ from every value the bench writes. Because the defaults are distinct, a slot that a soft reset fails to restore shows up directly. The 3-bit pointer also brings the unimplemented indices 6 and 7 within reach.

Three broken unlock orders are driven, and each is followed by a 0x5A:
- a wrong second byte
- a repeated first key
- a pointer write between the keys

These show that the armed state is abandoned rather than held.

// File: rtl/ibank_pkg.sv
package ibank_pkg;

    localparam int IDX_OWN   = 0;
    localparam int IDX_TOUT  = 1;
    localparam int IDX_MODE  = 2;
    localparam int IDX_SCLL  = 3;
    localparam int IDX_SCLH  = 4;
    localparam int IDX_RESET = 5;

    localparam int MODE_W = 2;

    typedef enum logic [1:0] {
        MODE_STD   = 2'd0,
        MODE_FAST  = 2'd1,
        MODE_FASTP = 2'd2,
        MODE_TURBO = 2'd3
    } bus_mode_t;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_ARMED = 2'd1,
        UL_FIRE  = 2'd2
    } ul_state_t;

endpackage

// File: rtl/ibank_unlock.sv
module ibank_unlock
    import ibank_pkg::*;
#(
    parameter int               DATA_W = 8,
    parameter logic [DATA_W-1:0] KEY1  = 8'hA5,
    parameter logic [DATA_W-1:0] KEY2  = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              sel,
    input  logic              on_reset_slot,
    input  logic [DATA_W-1:0] wdata,
    output logic              fire
);

    ul_state_t state_q, state_d;
    logic      key_wr;

    assign key_wr = wr && sel && on_reset_slot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UL_IDLE: begin
                if (key_wr && wdata == KEY1) state_d = UL_ARMED;
            end
            UL_ARMED: begin
                if (wr) begin
                    if (key_wr && wdata == KEY2) state_d = UL_FIRE;
                    else                         state_d = UL_IDLE;
                end
            end
            UL_FIRE: state_d = UL_IDLE;
            default: state_d = UL_IDLE;
        endcase
    end

    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            UL_FIRE: fire = 1'b1;
            default: fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/ibank_regs.sv
module ibank_regs
    import ibank_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                PTR_W    = 3,
    parameter logic [DATA_W-1:0] DEF_OWN  = 8'h60,
    parameter logic [DATA_W-1:0] DEF_TOUT = 8'hFF,
    parameter logic [MODE_W-1:0] DEF_MODE = 2'd0,
    parameter logic [DATA_W-1:0] DEF_SCLL = 8'h9D,
    parameter logic [DATA_W-1:0] DEF_SCLH = 8'h86
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr,
    input  logic              sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [PTR_W-1:0]  ptr,
    output logic [DATA_W-1:0] rdata,
    output logic [MODE_W-1:0] mode,
    output logic [DATA_W-1:0] scl_lo,
    output logic [DATA_W-1:0] scl_hi
);

    logic [DATA_W-1:0] own_q, tout_q;
    logic [DATA_W-1:0] slot_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr    <= '0;
            own_q  <= DEF_OWN;
            tout_q <= DEF_TOUT;
            mode   <= DEF_MODE;
            scl_lo <= DEF_SCLL;
            scl_hi <= DEF_SCLH;
        end else if (soft_rst) begin
            ptr    <= '0;
            own_q  <= DEF_OWN;
            tout_q <= DEF_TOUT;
            mode   <= DEF_MODE;
            scl_lo <= DEF_SCLL;
            scl_hi <= DEF_SCLH;
        end else if (wr && !sel) begin
            ptr <= wdata[PTR_W-1:0];
        end else if (wr && sel) begin
            case (int'(ptr))
                IDX_OWN:  own_q  <= wdata;
                IDX_TOUT: tout_q <= wdata;
                IDX_MODE: mode   <= wdata[MODE_W-1:0];
                IDX_SCLL: scl_lo <= wdata;
                IDX_SCLH: scl_hi <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (int'(ptr))
            IDX_OWN:  slot_rd = own_q;
            IDX_TOUT: slot_rd = tout_q;
            IDX_MODE: slot_rd = {{(DATA_W-MODE_W){1'b0}}, mode};
            IDX_SCLL: slot_rd = scl_lo;
            IDX_SCLH: slot_rd = scl_hi;
            default:  slot_rd = '0;
        endcase
    end

    assign rdata = sel ? slot_rd : {{(DATA_W-PTR_W){1'b0}}, ptr};

endmodule

// File: rtl/ibank_host.sv
module ibank_host
    import ibank_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                PTR_W    = 3,
    parameter logic [DATA_W-1:0] KEY1     = 8'hA5,
    parameter logic [DATA_W-1:0] KEY2     = 8'h5A,
    parameter logic [DATA_W-1:0] DEF_OWN  = 8'h60,
    parameter logic [DATA_W-1:0] DEF_TOUT = 8'hFF,
    parameter logic [1:0]        DEF_MODE = 2'd0,
    parameter logic [DATA_W-1:0] DEF_SCLL = 8'h9D,
    parameter logic [DATA_W-1:0] DEF_SCLH = 8'h86
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [1:0]        mode_o,
    output logic [DATA_W-1:0] scl_lo_o,
    output logic [DATA_W-1:0] scl_hi_o,
    output logic              soft_rst_o
);

    logic [PTR_W-1:0] ptr;
    logic             on_reset_slot;

    assign on_reset_slot = (int'(ptr) == IDX_RESET);

    ibank_unlock #(
        .DATA_W (DATA_W),
        .KEY1   (KEY1),
        .KEY2   (KEY2)
    ) u_unlock (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr            (host_wr),
        .sel           (host_sel),
        .on_reset_slot (on_reset_slot),
        .wdata         (host_wdata),
        .fire          (soft_rst_o)
    );

    ibank_regs #(
        .DATA_W   (DATA_W),
        .PTR_W    (PTR_W),
        .DEF_OWN  (DEF_OWN),
        .DEF_TOUT (DEF_TOUT),
        .DEF_MODE (DEF_MODE),
        .DEF_SCLL (DEF_SCLL),
        .DEF_SCLH (DEF_SCLH)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst_o),
        .wr       (host_wr),
        .sel      (host_sel),
        .wdata    (host_wdata),
        .ptr      (ptr),
        .rdata    (host_rdata),
        .mode     (mode_o),
        .scl_lo   (scl_lo_o),
        .scl_hi   (scl_hi_o)
    );

endmodule

// File: rtl/ibank_host_chk.sv
module ibank_host_chk #(
    parameter int                DATA_W   = 8,
    parameter int                PTR_W    = 3,
    parameter logic [DATA_W-1:0] KEY2     = 8'h5A,
    parameter logic [1:0]        DEF_MODE = 2'd0,
    parameter logic [DATA_W-1:0] DEF_SCLL = 8'h9D,
    parameter logic [DATA_W-1:0] DEF_SCLH = 8'h86
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_sel,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic [1:0]        mode_o,
    input logic [DATA_W-1:0] scl_lo_o,
    input logic [DATA_W-1:0] scl_hi_o,
    input logic              soft_rst_o
);

    a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o);

    a_r7_after_key2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> $past(host_wr && host_sel && host_wdata == KEY2));

    a_r8_defaults_back: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> (mode_o == DEF_MODE && scl_lo_o == DEF_SCLL && scl_hi_o == DEF_SCLH));

    a_r5_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && !soft_rst_o) |=> $stable(mode_o));

    a_r2_ptr_width: assert property (@(posedge clk) disable iff (!rst_n)
        !host_sel |-> host_rdata[DATA_W-1:PTR_W] == '0);

endmodule

bind ibank_host ibank_host_chk #(
    .DATA_W   (DATA_W),
    .PTR_W    (PTR_W),
    .KEY2     (KEY2),
    .DEF_MODE (DEF_MODE),
    .DEF_SCLL (DEF_SCLL),
    .DEF_SCLH (DEF_SCLH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .mode_o     (mode_o),
    .scl_lo_o   (scl_lo_o),
    .scl_hi_o   (scl_hi_o),
    .soft_rst_o (soft_rst_o)
);

// File: tb/tb_ibank_host.sv
`timescale 1ns/1ps
module tb_ibank_host;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_sel = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [1:0] mode_o;
    logic [7:0] scl_lo_o, scl_hi_o;
    logic       soft_rst_o;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    ibank_host dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mode_o(mode_o),
        .scl_lo_o(scl_lo_o), .scl_hi_o(scl_hi_o), .soft_rst_o(soft_rst_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        host_sel = sel;
        #1 d = host_rdata;
    endtask

    task automatic rd_slot(input logic [7:0] idx, output logic [7:0] d);
        wr(1'b0, idx);
        rd(1'b1, d);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(1'b0, v);        check("R1 pointer", v, 8'h00);
        rd_slot(0, v);      check("R1 own", v, 8'h60);
        rd_slot(1, v);      check("R1 timeout", v, 8'hFF);
        check("R1 mode_o", {6'd0, mode_o}, 8'h00);
        check("R1 scl_lo_o", scl_lo_o, 8'h9D);
        check("R1 scl_hi_o", scl_hi_o, 8'h86);
        check("R1 soft_rst_o", {7'd0, soft_rst_o}, 8'h00);
    endtask

    task automatic t_pointer;
        logic [7:0] v;
        wr(1'b0, 8'hFC);
        rd(1'b0, v); check("R2 pointer low bits", v, 8'h04);
        wr(1'b0, 8'h03);
        rd(1'b0, v); check("R2 pointer readback", v, 8'h03);
    endtask

    task automatic t_probe;
        logic [7:0] v;
        wr(1'b0, 8'h00); wr(1'b1, 8'hAA);
        wr(1'b0, 8'h01); wr(1'b1, 8'h00);
        rd(1'b1, v);     check("R3 timeout written", v, 8'h00);
        rd_slot(0, v);   check("R4 own address survives", v, 8'hAA);
    endtask

    task automatic t_mode;
        logic [7:0] v;
        wr(1'b0, 8'h02); wr(1'b1, 8'hFF);
        check("R5 mode_o turbo", {6'd0, mode_o}, 8'h03);
        rd(1'b1, v); check("R5 mode upper bits zero", v, 8'h03);
        wr(1'b1, 8'h02);
        check("R5 mode_o fast-plus", {6'd0, mode_o}, 8'h02);
    endtask

    task automatic t_scl;
        logic [7:0] v;
        wr(1'b0, 8'h03); wr(1'b1, 8'h11);
        check("R6 scl_lo_o", scl_lo_o, 8'h11);
        check("R6 scl_hi_o unchanged", scl_hi_o, 8'h86);
        wr(1'b0, 8'h04); wr(1'b1, 8'h22);
        check("R6 scl_hi_o", scl_hi_o, 8'h22);
        check("R6 scl_lo_o kept", scl_lo_o, 8'h11);
        rd(1'b1, v); check("R3 scl high readback", v, 8'h22);
    endtask

    task automatic t_unimpl;
        logic [7:0] v;
        for (int i = 5; i < 8; i++) begin
            wr(1'b0, 8'(i)); wr(1'b1, 8'h77);
            rd(1'b1, v); check("R10 unimplemented read", v, 8'h00);
        end
        check("R10 scl_lo_o untouched", scl_lo_o, 8'h11);
        check("R10 scl_hi_o untouched", scl_hi_o, 8'h22);
        check("R10 mode_o untouched", {6'd0, mode_o}, 8'h02);
        rd_slot(0, v); check("R10 own untouched", v, 8'hAA);
    endtask

    task automatic t_broken;
        wr(1'b0, 8'h05);
        wr(1'b1, 8'hA5); wr(1'b1, 8'h33); wr(1'b1, 8'h5A);
        check("R9 wrong byte no pulse", {7'd0, soft_rst_o}, 8'h00);
        wr(1'b1, 8'hA5); wr(1'b1, 8'hA5); wr(1'b1, 8'h5A);
        check("R9 repeated key no pulse", {7'd0, soft_rst_o}, 8'h00);
        wr(1'b1, 8'hA5); wr(1'b0, 8'h05); wr(1'b1, 8'h5A);
        check("R9 pointer write breaks", {7'd0, soft_rst_o}, 8'h00);
        check("R9 state kept", scl_hi_o, 8'h22);
    endtask

    task automatic t_unlock;
        logic [7:0] v;
        wr(1'b0, 8'h05);
        wr(1'b1, 8'hA5);
        check("R7 no pulse after first key", {7'd0, soft_rst_o}, 8'h00);
        wr(1'b1, 8'h5A);
        check("R7 pulse high", {7'd0, soft_rst_o}, 8'h01);
        @(negedge clk);
        check("R7 pulse one cycle", {7'd0, soft_rst_o}, 8'h00);
        check("R8 mode_o default", {6'd0, mode_o}, 8'h00);
        check("R8 scl_lo_o default", scl_lo_o, 8'h9D);
        check("R8 scl_hi_o default", scl_hi_o, 8'h86);
        rd(1'b0, v); check("R8 pointer default", v, 8'h00);
        rd(1'b1, v); check("R8 own default", v, 8'h60);
        rd_slot(1, v); check("R8 timeout default", v, 8'hFF);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pointer();
        t_probe();
        t_mode();
        t_scl();
        t_unimpl();
        t_broken();
        t_unlock();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule